// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This unit gathers the interrupt conditions of a FIFO-equipped UART and ranks them. It registers a single interrupt line that stays high while any enabled condition is pending. When the host reads the identification register, the unit returns an 8-bit code naming the most urgent pending source. The serial datapath, the baud logic and the FIFO storage sit outside the unit. Their conditions arrive either as level flags or as one-cycle event pulses.

The unit has seven sources. Five are the classic ones. Two more are visible only while an enhanced-features enable is high: a received Xoff or special-character match, and a change on the flow-control pins. Three sources are held in internal flags. The transmit-ready flag and the flow-change flag clear when the host reads the register while that source is the one reported. The Xoff flag is sticky and clears only when an Xon arrives. The unit also holds the FIFO-control enable bit, the receive trigger level and the FIFO clear strobes. A write to that control register changes anything other than the enable bit only when the same write also sets the enable bit.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and after it is released, `id_data` = 8'h01, `irq` = 0, `fifo_on` = 0, `rx_trig` = 0, and both clear strobes are 0.
- R2: A source index selects its bit of `src_en`: 0 line status, 1 receive time-out, 2 receive data ready, 3 transmit ready, 4 modem status, 5 Xoff match, 6 flow-pin change. The lowest index that is pending and enabled wins. Bits 3:0 of the code are 0110, 1100, 0100, 0010 and 0000 for indices 0 to 4, and 0000 for indices 5 and 6. With no winner, bits 3:0 are 0001.
- R3: A source whose `src_en` bit is 0 takes no part in the ranking. `irq` is 1 one cycle after any enabled source is pending, and 0 one cycle after none is.
- R4: Bits 7:6 of the code both equal `fifo_on`.
- R5: When `enh_en` = 0, bits 5:4 read 0 and sources 5 and 6 are excluded from the ranking. When `enh_en` = 1, bit 4 shows the Xoff flag and bit 5 shows the flow-change flag.
- R6: `xoff_seen` sets the Xoff flag. Reads leave it unchanged. `xon_seen` clears it, and `xon_seen` wins when both pulses arrive in the same cycle.
- R7: `tx_ready_set` sets the transmit-ready flag. `thr_load` clears it, and so does a read that reports it. A set in the same cycle as either clear leaves the flag set. A read that reports another source leaves the flag unchanged.
- R8: `flow_chg` sets the flow-change flag. A read that reports it clears it, and a set in the same cycle as that read leaves it set.
- R9: `id_data` takes a new value only at a clock edge where `id_rd` = 1. That value is computed from the state before that edge. Later changes appear only at the next read.
- R10: A control write with `fcr_en_bit` = 0 clears `fifo_on` and changes nothing else. A write with `fcr_en_bit` = 1 sets `fifo_on` and loads `rx_trig` from `fcr_trig`.
- R11: On a write with `fcr_en_bit` = 1, `rx_fifo_clr` and `tx_fifo_clr` each pulse for exactly one cycle, one cycle after the write, when their request bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsr_cond | input | 1 | Receiver line-status condition (level) |
| rxto_cond | input | 1 | Receive time-out condition (level) |
| rxrdy_cond | input | 1 | Receive data ready condition (level) |
| msr_cond | input | 1 | Modem-status change condition (level) |
| tx_ready_set | input | 1 | Transmit became ready (pulse) |
| thr_load | input | 1 | Host loaded transmit data (pulse) |
| xoff_seen | input | 1 | Xoff or special character matched (pulse) |
| xon_seen | input | 1 | Xon character received (pulse) |
| flow_chg | input | 1 | Flow-control pin changed state (pulse) |
| src_en | input | 7 | Per-source enables, indexed as in R2 |
| enh_en | input | 1 | Enhanced-features enable |
| id_rd | input | 1 | Host read strobe for the identification register |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_en_bit | input | 1 | Written FIFO enable bit |
| fcr_rxclr_bit | input | 1 | Written receive FIFO clear request |
| fcr_txclr_bit | input | 1 | Written transmit FIFO clear request |
| fcr_trig | input | 2 | Written receive trigger level |
| id_data | output | 8 | Identification byte captured at the last read |
| irq | output | 1 | Interrupt line |
| fifo_on | output | 1 | FIFO enable state |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |
| rx_trig | output | 2 | Receive trigger level |

## Verification
The host read and a new event on a read-cleared flag can land in the same cycle. Examples are a read that reports transmit ready while `tx_ready_set` pulses, or a read that reports the flow change while `flow_chg` pulses. The bench drives both strobes on one edge. It then checks that the returned byte names the source and that a second read still reports it. The same-cycle pair of Xoff and Xon is driven the same way, and the bench expects the flag to end up clear. A line-status condition raised just after a read is checked to leave `id_data` unchanged until the next read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC   = 7;
    localparam int CODE_W = 4;
    localparam int ID_W   = 8;
    localparam int TRIG_W = 2;

    localparam int IDX_LSR   = 0;
    localparam int IDX_RXTO  = 1;
    localparam int IDX_RXRDY = 2;
    localparam int IDX_TX    = 3;
    localparam int IDX_MSR   = 4;
    localparam int IDX_XOFF  = 5;
    localparam int IDX_FLOW  = 6;

    localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

    // bits 3:0 of the identification byte for the winning source index
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            IDX_LSR:   return 4'b0110;
            IDX_RXTO:  return 4'b1100;
            IDX_RXRDY: return 4'b0100;
            IDX_TX:    return 4'b0010;
            default:   return 4'b0000;
        endcase
    endfunction

    typedef struct packed {
        logic txf;
        logic xoff;
        logic flow;
    } flags_t;

    typedef struct packed {
        logic              on;
        logic              rxc;
        logic              txc;
        logic [TRIG_W-1:0] trig;
    } fctl_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            irq;
    } ident_t;

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    output logic [N-1:0]      grant,
    output logic              any,
    output logic [CODE_W-1:0] code
);

    // fixed priority: lower index wins
    generate
        for (genvar i = 0; i < N; i++) begin : g_grant
            if (i == 0) begin : g_top
                assign grant[i] = req[i];
            end else begin : g_rest
                assign grant[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

    assign any = |req;

    always_comb begin
        code = CODE_NONE;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = src_code(i);
        end
    end

    // R2: at most one winner, and a winner exactly when something requests
    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant != '0) == (req != '0)));

endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
    import uart_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tx_set,
    input  logic   tx_load,
    input  logic   tx_rd_clr,
    input  logic   xoff_set,
    input  logic   xon_clr,
    input  logic   flow_set,
    input  logic   flow_rd_clr,
    output flags_t flags
);

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // new events win over same-cycle clears
        if (tx_set)                     fl_d.txf = 1'b1;
        else if (tx_load || tx_rd_clr)  fl_d.txf = 1'b0;
        // Xon wins over a same-cycle Xoff
        if (xon_clr)                    fl_d.xoff = 1'b0;
        else if (xoff_set)              fl_d.xoff = 1'b1;
        if (flow_set)                   fl_d.flow = 1'b1;
        else if (flow_rd_clr)           fl_d.flow = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    a_r6_xon_clears: assert property (@(posedge clk) disable iff (!rst_n)
        xon_clr |=> !fl_q.xoff);
    a_r6_xoff_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_set && !xon_clr) |=> fl_q.xoff);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> fl_q.txf);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flow_set |=> fl_q.flow);

endmodule

// File: rtl/uart_irq_fifo_ctl.sv
module uart_irq_fifo_ctl
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              en_bit,
    input  logic              rxclr_bit,
    input  logic              txclr_bit,
    input  logic [TRIG_W-1:0] trig_in,
    output logic              on,
    output logic              rx_clr,
    output logic              tx_clr,
    output logic [TRIG_W-1:0] trig
);

    fctl_t fc_d, fc_q;

    always_comb begin
        fc_d     = fc_q;
        fc_d.rxc = 1'b0;
        fc_d.txc = 1'b0;
        if (wr) begin
            fc_d.on = en_bit;
            // other fields only take effect when enable is written as 1
            if (en_bit) begin
                fc_d.trig = trig_in;
                fc_d.rxc  = rxclr_bit;
                fc_d.txc  = txclr_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fc_q <= '0;
        else        fc_q <= fc_d;
    end

    assign on     = fc_q.on;
    assign rx_clr = fc_q.rxc;
    assign tx_clr = fc_q.txc;
    assign trig   = fc_q.trig;

    a_r10_gated_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !en_bit) |=> ($stable(fc_q.trig) && !fc_q.on));
    a_r11_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fc_q.rxc |-> $past(wr && en_bit && rxclr_bit));
    a_r11_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fc_q.txc |-> $past(wr && en_bit && txclr_bit));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsr_cond,
    input  logic              rxto_cond,
    input  logic              rxrdy_cond,
    input  logic              msr_cond,
    input  logic              tx_ready_set,
    input  logic              thr_load,
    input  logic              xoff_seen,
    input  logic              xon_seen,
    input  logic              flow_chg,
    input  logic [NSRC-1:0]   src_en,
    input  logic              enh_en,
    input  logic              id_rd,
    input  logic              fcr_wr,
    input  logic              fcr_en_bit,
    input  logic              fcr_rxclr_bit,
    input  logic              fcr_txclr_bit,
    input  logic [TRIG_W-1:0] fcr_trig,
    output logic [ID_W-1:0]   id_data,
    output logic              irq,
    output logic              fifo_on,
    output logic              rx_fifo_clr,
    output logic              tx_fifo_clr,
    output logic [TRIG_W-1:0] rx_trig
);

    flags_t            flags;
    logic [NSRC-1:0]   req;
    logic [NSRC-1:0]   grant;
    logic              any_req;
    logic [CODE_W-1:0] code;
    logic [ID_W-1:0]   live_id;
    ident_t            st_d, st_q;

    uart_irq_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_set      (tx_ready_set),
        .tx_load     (thr_load),
        .tx_rd_clr   (id_rd && grant[IDX_TX]),
        .xoff_set    (xoff_seen),
        .xon_clr     (xon_seen),
        .flow_set    (flow_chg),
        .flow_rd_clr (id_rd && grant[IDX_FLOW]),
        .flags       (flags)
    );

    uart_irq_fifo_ctl u_fctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (fcr_wr),
        .en_bit    (fcr_en_bit),
        .rxclr_bit (fcr_rxclr_bit),
        .txclr_bit (fcr_txclr_bit),
        .trig_in   (fcr_trig),
        .on        (fifo_on),
        .rx_clr    (rx_fifo_clr),
        .tx_clr    (tx_fifo_clr),
        .trig      (rx_trig)
    );

    uart_irq_prio #(.N(NSRC)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant),
        .any   (any_req),
        .code  (code)
    );

    always_comb begin
        req = {flags.flow & enh_en, flags.xoff & enh_en, msr_cond, flags.txf,
               rxrdy_cond, rxto_cond, lsr_cond} & src_en;
        live_id = {fifo_on, fifo_on, enh_en & flags.flow, enh_en & flags.xoff, code};
        st_d     = st_q;
        st_d.irq = any_req;
        if (id_rd) st_d.id = live_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.id  <= {{(ID_W-CODE_W){1'b0}}, CODE_NONE};
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign id_data = st_q.id;
    assign irq     = st_q.irq;

    a_r9_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !id_rd |=> $stable(id_data));
    a_r4_fifo_bits_pair: assert property (@(posedge clk) disable iff (!rst_n)
        id_data[7] == id_data[6]);
    a_r5_hidden_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && !enh_en) |=> (id_data[5:4] == 2'b00));

endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lsr_cond = 0, rxto_cond = 0, rxrdy_cond = 0, msr_cond = 0;
    logic       tx_ready_set = 0, thr_load = 0, xoff_seen = 0, xon_seen = 0, flow_chg = 0;
    logic [6:0] src_en = '0;
    logic       enh_en = 0, id_rd = 0;
    logic       fcr_wr = 0, fcr_en_bit = 0, fcr_rxclr_bit = 0, fcr_txclr_bit = 0;
    logic [1:0] fcr_trig = '0;
    logic [7:0] id_data;
    logic       irq, fifo_on, rx_fifo_clr, tx_fifo_clr;
    logic [1:0] rx_trig;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst_n(rst_n),
        .lsr_cond(lsr_cond), .rxto_cond(rxto_cond), .rxrdy_cond(rxrdy_cond),
        .msr_cond(msr_cond), .tx_ready_set(tx_ready_set), .thr_load(thr_load),
        .xoff_seen(xoff_seen), .xon_seen(xon_seen), .flow_chg(flow_chg),
        .src_en(src_en), .enh_en(enh_en), .id_rd(id_rd),
        .fcr_wr(fcr_wr), .fcr_en_bit(fcr_en_bit), .fcr_rxclr_bit(fcr_rxclr_bit),
        .fcr_txclr_bit(fcr_txclr_bit), .fcr_trig(fcr_trig),
        .id_data(id_data), .irq(irq), .fifo_on(fifo_on),
        .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr), .rx_trig(rx_trig)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // independent model of the identification byte
    function automatic logic [7:0] exp_id(input logic [6:0] p, input logic [6:0] e,
                                          input logic enh, input logic fifo);
        logic [6:0] m;
        logic [3:0] c;
        m = p;
        if (!enh) m[6:5] = 2'b00;
        m = m & e;
        c = 4'b0001;
        for (int i = 6; i >= 0; i--) begin
            if (m[i]) begin
                case (i)
                    0: c = 4'b0110;
                    1: c = 4'b1100;
                    2: c = 4'b0100;
                    3: c = 4'b0010;
                    default: c = 4'b0000;
                endcase
            end
        end
        return {fifo, fifo, enh & p[6], enh & p[5], c};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        lsr_cond = 0; rxto_cond = 0; rxrdy_cond = 0; msr_cond = 0;
        tx_ready_set = 0; thr_load = 0; xoff_seen = 0; xon_seen = 0; flow_chg = 0;
        id_rd = 0; fcr_wr = 0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic rd(input string req, input logic [7:0] exp);
        id_rd = 1; cyc(); id_rd = 0;
        chk(req, id_data, exp);
    endtask

    task automatic fcr(input logic en, input logic rc, input logic tc, input logic [1:0] tg);
        fcr_wr = 1; fcr_en_bit = en; fcr_rxclr_bit = rc; fcr_txclr_bit = tc; fcr_trig = tg;
        cyc();
        fcr_wr = 0; fcr_en_bit = 0; fcr_rxclr_bit = 0; fcr_txclr_bit = 0; fcr_trig = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        rst_n = 0; cyc();
        chk("R1 id in reset", id_data, 8'h01);
        do_reset(); cyc();
        chk("R1 id", id_data, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 fifo_on/trig", {5'd0, fifo_on, rx_trig}, 8'h00);
        chk("R1 clr strobes", {6'd0, rx_fifo_clr, tx_fifo_clr}, 8'h00);

        // R2 R3 R4 R5 sweep: every pending pattern under four configurations
        for (int mode = 0; mode < 4; mode++) begin
            for (int pi = 0; pi < 128; pi++) begin
                logic [6:0] p, e;
                logic enh, fifo;
                p = pi[6:0];
                case (mode)
                    0: begin e = 7'h7f; enh = 1; fifo = 1; end
                    1: begin e = 7'h7f; enh = 0; fifo = 0; end
                    2: begin e = 7'h55; enh = 1; fifo = 0; end
                    default: begin e = 7'h2a; enh = 1; fifo = 1; end
                endcase
                do_reset();
                if (fifo) fcr(1'b1, 1'b0, 1'b0, 2'b00);
                tx_ready_set = p[3]; xoff_seen = p[5]; flow_chg = p[6];
                cyc();
                tx_ready_set = 0; xoff_seen = 0; flow_chg = 0;
                lsr_cond = p[0]; rxto_cond = p[1]; rxrdy_cond = p[2]; msr_cond = p[4];
                src_en = e; enh_en = enh;
                cyc();
                rd("R2 R4 R5 sweep code", exp_id(p, e, enh, fifo));
                begin
                    logic [6:0] m;
                    m = p;
                    if (!enh) m[6:5] = 2'b00;
                    chk("R3 sweep irq", {7'd0, irq}, {7'd0, |(m & e)});
                end
            end
        end

        // directed cases: all sources enabled, enhanced on, FIFOs off
        do_reset(); src_en = 7'h7f; enh_en = 1; cyc();

        // R6 Xoff sticky
        xoff_seen = 1; cyc(); xoff_seen = 0;
        rd("R6 xoff reported", 8'h10);
        rd("R6 read leaves xoff", 8'h10);
        xon_seen = 1; cyc(); xon_seen = 0;
        rd("R6 xon clears", 8'h01);
        xoff_seen = 1; xon_seen = 1; cyc(); xoff_seen = 0; xon_seen = 0;
        rd("R6 xon wins same cycle", 8'h01);

        // R7 transmit ready
        tx_ready_set = 1; cyc(); tx_ready_set = 0;
        rd("R7 tx reported", 8'h02);
        rd("R7 read cleared tx", 8'h01);
        tx_ready_set = 1; cyc(); tx_ready_set = 0;
        lsr_cond = 1; cyc();
        rd("R7 lsr outranks tx", 8'h06);
        lsr_cond = 0; cyc();
        rd("R7 tx kept when not reported", 8'h02);
        tx_ready_set = 1; cyc(); tx_ready_set = 0;
        thr_load = 1; cyc(); thr_load = 0;
        rd("R7 thr_load clears", 8'h01);
        tx_ready_set = 1; cyc();
        id_rd = 1; cyc(); id_rd = 0; tx_ready_set = 0;
        chk("R7 read with same-cycle set", id_data, 8'h02);
        rd("R7 set wins over read clear", 8'h02);
        rd("R7 then cleared", 8'h01);

        // R8 flow change
        flow_chg = 1; cyc(); flow_chg = 0;
        rd("R8 flow reported", 8'h20);
        rd("R8 read cleared flow", 8'h01);
        flow_chg = 1; cyc();
        id_rd = 1; cyc(); id_rd = 0; flow_chg = 0;
        chk("R8 read with same-cycle set", id_data, 8'h20);
        rd("R8 set wins over read clear", 8'h20);
        rd("R8 then cleared", 8'h01);

        // R9 byte held between reads
        lsr_cond = 1; cyc(); cyc();
        chk("R9 held after lsr rises", id_data, 8'h01);
        chk("R3 irq with lsr", {7'd0, irq}, 8'h01);
        rd("R9 next read shows lsr", 8'h06);
        lsr_cond = 0; cyc(); cyc();
        chk("R9 held after lsr falls", id_data, 8'h06);
        chk("R3 irq drops", {7'd0, irq}, 8'h00);

        // R10 R11 FIFO control gating
        fcr(1'b0, 1'b1, 1'b1, 2'b11);
        chk("R10 no-enable write", {4'd0, fifo_on, rx_fifo_clr, rx_trig}, 8'h00);
        chk("R11 no strobe without enable", {7'd0, tx_fifo_clr}, 8'h00);
        fcr(1'b1, 1'b1, 1'b1, 2'b11);
        chk("R10 enable write", {5'd0, fifo_on, rx_trig}, 8'h07);
        chk("R11 strobes", {6'd0, rx_fifo_clr, tx_fifo_clr}, 8'h03);
        cyc();
        chk("R11 strobes one cycle", {6'd0, rx_fifo_clr, tx_fifo_clr}, 8'h00);
        rd("R4 fifo bits set", 8'hc1);
        fcr(1'b0, 1'b0, 1'b0, 2'b01);
        chk("R10 disable keeps trig", {5'd0, fifo_on, rx_trig}, 8'h03);
        rd("R4 fifo bits clear", 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule